// File: doc/BRIEF.md
# Reactive Signal and Preemption Unit

This block is the reactive part of a small processor core. The control unit hands it one decoded operation per cycle, together with the instruction word and the current program counter. The block drives a 16-bit output signal port and samples a 16-bit input signal port. It carries out single-cycle pulses and latched outputs on the output port. It carries out waits and tests on the input port. It runs two count-down timers whose timeouts feed back as internal input signals. It also keeps a small stack of armed abort contexts.

The block answers the control unit with a stall (hold the current operation) and a redirect with a target address. An armed abort context watches one input signal. When that signal appears, the unit redirects to the context's continuation address in the same cycle, whatever operation is executing. When execution reaches the continuation address on its own, the context is disarmed without a redirect.

Top module: `react_unit`

## Requirements
- R1: Operations are taken only in cycles with `op_valid` high. `op_code` is decoded as 0 timer load, 1 pulse, 2 latch, 3 wait, 4 dual wait, 5 test, 6 delay, 7 abort arm. Instruction fields: value/address in bits 24..9, first signal index in bits 8..5, second signal index in bits 4..1, timer select in bit 0.
- R2: A pulse operation drives output bits 15..0 from instruction bits 24..9. It raises the selected bits in the following cycle only, and several bits may rise together.
- R3: A latch operation ORs instruction bits 24..9 into a set of held outputs. Those outputs stay high until reset.
- R4: The effective input vector is `sig_in`, with timer 0's timeout ORed into bit 14 and timer 1's into bit 15. A wait operation stalls while the effective bit at the first index is low and completes in the cycle it is high.
- R5: A dual wait stalls while both indexed bits are low. It completes without redirect when the first is high, which takes priority. When only the second is high, it redirects to bits 24..9.
- R6: A test operation completes in one cycle. It redirects to bits 24..9 when the first indexed bit is low and falls through when it is high.
- R7: A delay operation with count N in bits 24..9 stalls for exactly N cycles and then completes; N = 0 does not stall.
- R8: A timer load with count N > 0 in bits 24..9, selecting the timer with bit 0, produces a one-cycle timeout on that timer's effective bit N+1 cycles after the load cycle. Loading 0 stops the timer.
- R9: An abort arm pushes (first index, bits 24..9). In any cycle in which an armed level's effective bit is high, the unit redirects to that level's address in that cycle and does not stall. An abort arm issued in that cycle is dropped. Pulse, latch and timer load effects of that cycle still take place, and a pending delay is cancelled.
- R10: When several armed levels fire together, the outermost (earliest armed) wins, and it and every level armed after it are removed.
- R11: When an operation completes, without stall, at a program counter equal to the address of an armed level, the innermost such level alone is removed, with no redirect.
- R12: At most four levels are held. Arming a fifth leaves the stack unchanged and sets `abort_ovf`, which stays high until reset.
- R13: Reset clears pulsed and held outputs, the abort stack, the overflow flag, both timers and any pending delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Decoded operation present this cycle |
| op_code | input | 3 | Decoded operation kind |
| instr | input | 32 | Instruction word |
| pc | input | 16 | Program counter of the current operation |
| sig_in | input | 16 | Input signal port |
| sig_out | output | 16 | Output signal port |
| stall | output | 1 | Hold the current operation |
| redirect | output | 1 | Take `redirect_addr` as the next program counter |
| redirect_addr | output | 16 | Redirect target |
| abort_ovf | output | 1 | Sticky abort-stack overflow flag |

## Verification
The waits are driven with the watched signal absent for several cycles and then present. This separates the stall from the completion. Dual waits are driven with neither, only the second, both and only the first signal present, so priority and redirect can be told apart. Abort preemption is tried with one level, with two of three nested levels firing at once (this exposes outermost-wins and the depth of the pop), and with normal exits at shared and distinct continuation addresses. It is also tried against a running delay and against a full stack. Timer feedback is checked by waiting on the timeout bit, and a reset taken with latched outputs, armed levels and a running timer shows that every piece of state is cleared.

// File: rtl/react_pkg.sv
package react_pkg;
    parameter int SIG_W  = 16;
    parameter int ADDR_W = 16;
    parameter int IDX_W  = $clog2(SIG_W);
    parameter int INS_W  = 32;

    // instruction field positions
    parameter int F_VAL_LO = 9;
    parameter int F_VAL_HI = F_VAL_LO + SIG_W - 1;
    parameter int F_IA_LO  = 5;
    parameter int F_IB_LO  = 1;

    typedef enum logic [2:0] {
        OP_TLOAD   = 3'd0,
        OP_PULSE   = 3'd1,
        OP_LATCH   = 3'd2,
        OP_WAIT    = 3'd3,
        OP_DWAIT   = 3'd4,
        OP_TEST    = 3'd5,
        OP_DELAY   = 3'd6,
        OP_ABORT   = 3'd7
    } op_e;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
    } abort_ent_t;

    typedef struct packed {
        logic [SIG_W-1:0] pulse;
        logic [SIG_W-1:0] held;
        logic             dly_busy;
        logic [SIG_W-1:0] dly_cnt;
    } core_st_t;
endpackage

// File: rtl/react_timer.sv
module react_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          tmo_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tmo;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.tmo = (st_q.cnt == CW'(1));
        if (load_i)
            st_d.cnt = val_i;
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmo_o = st_q.tmo;

    // R8
    tmr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> st_q.cnt == $past(val_i));
endmodule

// File: rtl/react_abort_stack.sv
module react_abort_stack
    import react_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SIG_W-1:0]  eff_i,
    input  logic              push_i,
    input  logic [IDX_W-1:0]  push_idx_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic              done_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic              fire_o,
    output logic [ADDR_W-1:0] fire_addr_o,
    output logic              ovf_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        abort_ent_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0]       cnt;
        logic                   ovf;
    } stk_st_t;

    stk_st_t st_d, st_q;
    int      fire_k;
    int      hit_k;
    logic    hit;

    always_comb begin
        st_d        = st_q;
        fire_o      = 1'b0;
        fire_k      = 0;
        fire_addr_o = '0;
        hit         = 1'b0;
        hit_k       = 0;
        // outermost firing level wins: scan from the top, keep the lowest
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (k < int'(st_q.cnt) && eff_i[st_q.ent[k].idx]) begin
                fire_o      = 1'b1;
                fire_k      = k;
                fire_addr_o = st_q.ent[k].addr;
            end
        end
        // innermost level whose continuation is reached
        for (int k = 0; k < DEPTH; k++) begin
            if (done_i && k < int'(st_q.cnt) && st_q.ent[k].addr == pc_i) begin
                hit   = 1'b1;
                hit_k = k;
            end
        end
        if (fire_o) begin
            st_d.cnt = CNT_W'(fire_k);
        end else begin
            if (hit) begin
                for (int k = 0; k < DEPTH - 1; k++)
                    if (k >= hit_k) st_d.ent[k] = st_q.ent[k+1];
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
            if (push_i) begin
                if (st_d.cnt < CNT_W'(DEPTH)) begin
                    for (int k = 0; k < DEPTH; k++)
                        if (k == int'(st_d.cnt)) begin
                            st_d.ent[k].idx  = push_idx_i;
                            st_d.ent[k].addr = push_addr_i;
                        end
                    st_d.cnt = st_d.cnt + CNT_W'(1);
                end else begin
                    st_d.ovf = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf_o = st_q.ovf;

    // R10
    stk_fire_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> st_q.cnt < $past(st_q.cnt));

    // R12
    stk_full_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !fire_o && !done_i && st_q.cnt == CNT_W'(DEPTH))
        |=> (ovf_o && st_q.cnt == CNT_W'(DEPTH)));

    // R12
    stk_ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);
endmodule

// File: rtl/react_unit.sv
module react_unit
    import react_pkg::*;
#(
    parameter int ABORT_DEPTH = 4,
    parameter int NUM_TIMERS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [INS_W-1:0]  instr,
    input  logic [ADDR_W-1:0] pc,
    input  logic [SIG_W-1:0]  sig_in,
    output logic [SIG_W-1:0]  sig_out,
    output logic              stall,
    output logic              redirect,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic              abort_ovf
);
    localparam int TSEL_W = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1;

    core_st_t               st_d, st_q;
    logic [SIG_W-1:0]       eff;
    logic [SIG_W-1:0]       fld_val;
    logic [IDX_W-1:0]       idx_a, idx_b;
    logic [NUM_TIMERS-1:0]  tmo, tload;
    logic                   fire, stall_raw, redir_raw, done, push;
    logic [ADDR_W-1:0]      fire_addr;
    logic                   unused_hi;

    assign fld_val   = instr[F_VAL_HI:F_VAL_LO];
    assign idx_a     = instr[F_IA_LO +: IDX_W];
    assign idx_b     = instr[F_IB_LO +: IDX_W];
    assign unused_hi = ^instr[INS_W-1:F_VAL_HI+1];

    // timeouts fold into the top input indexes
    always_comb begin
        eff = sig_in;
        for (int t = 0; t < NUM_TIMERS; t++)
            eff[SIG_W-NUM_TIMERS+t] = sig_in[SIG_W-NUM_TIMERS+t] | tmo[t];
    end

    generate
        for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
            assign tload[t] = op_valid && op_code == OP_TLOAD
                              && instr[TSEL_W-1:0] == TSEL_W'(t);
            react_timer #(.CW(SIG_W)) u_tmr (
                .clk    (clk),
                .rst_n  (rst_n),
                .load_i (tload[t]),
                .val_i  (fld_val),
                .tmo_o  (tmo[t])
            );
        end
    endgenerate

    always_comb begin
        stall_raw = 1'b0;
        redir_raw = 1'b0;
        if (op_valid) begin
            case (op_e'(op_code))
                OP_WAIT:  stall_raw = !eff[idx_a];
                OP_DWAIT: begin
                    stall_raw = !eff[idx_a] && !eff[idx_b];
                    redir_raw = !eff[idx_a] &&  eff[idx_b];
                end
                OP_TEST:  redir_raw = !eff[idx_a];
                OP_DELAY: stall_raw = st_q.dly_busy ? (st_q.dly_cnt != '0)
                                                    : (fld_val != '0);
                default:  ;
            endcase
        end
    end

    assign done = op_valid && !stall_raw;
    assign push = op_valid && op_code == OP_ABORT;

    react_abort_stack #(.DEPTH(ABORT_DEPTH)) u_stk (
        .clk         (clk),
        .rst_n       (rst_n),
        .eff_i       (eff),
        .push_i      (push),
        .push_idx_i  (idx_a),
        .push_addr_i (fld_val),
        .done_i      (done),
        .pc_i        (pc),
        .fire_o      (fire),
        .fire_addr_o (fire_addr),
        .ovf_o       (abort_ovf)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = (op_valid && op_code == OP_PULSE) ? fld_val : '0;
        if (op_valid && op_code == OP_LATCH)
            st_d.held = st_q.held | fld_val;
        if (fire || !(op_valid && op_code == OP_DELAY)) begin
            st_d.dly_busy = 1'b0;
            st_d.dly_cnt  = '0;
        end else if (!st_q.dly_busy) begin
            if (fld_val != '0) begin
                st_d.dly_busy = 1'b1;
                st_d.dly_cnt  = fld_val - SIG_W'(1);
            end
        end else if (st_q.dly_cnt == '0) begin
            st_d.dly_busy = 1'b0;
        end else begin
            st_d.dly_cnt = st_q.dly_cnt - SIG_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sig_out       = st_q.pulse | st_q.held;
    assign stall         = stall_raw && !fire;
    assign redirect      = fire || redir_raw;
    assign redirect_addr = fire ? fire_addr : fld_val;

    // R2
    pulse_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_PULSE)
        |=> (sig_out & $past(fld_val)) == $past(fld_val));

    // R4
    wait_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_WAIT && !eff[idx_a] && !fire) |-> stall);

    // R9
    fire_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (redirect && !stall && redirect_addr == fire_addr));
endmodule

// File: tb/sim_react_unit.sv
`timescale 1ns/1ps
module sim_react_unit;
    import react_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [31:0] instr = '0;
    logic [15:0] pc = '0;
    logic [15:0] sig_in = '0;
    logic [15:0] sig_out;
    logic        stall, redirect, abort_ovf;
    logic [15:0] redirect_addr;

    always #4 clk = ~clk;

    react_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .instr(instr), .pc(pc), .sig_in(sig_in), .sig_out(sig_out),
        .stall(stall), .redirect(redirect), .redirect_addr(redirect_addr),
        .abort_ovf(abort_ovf)
    );

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    logic [15:0] m_pulse, m_held;
    int          m_tmr [2];
    bit          m_tmo [2];
    bit          m_busy;
    int          m_cnt;
    int          m_idx [$];
    int          m_addr [$];
    bit          m_ovf;
    logic [15:0] pcv;

    function automatic logic [31:0] mk(input logic [15:0] v, input int a,
                                       input int b, input bit sel);
        return {7'b0, v, 4'(a), 4'(b), sel};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_pulse = '0; m_held = '0; m_busy = 0; m_cnt = 0; m_ovf = 0;
        for (int i = 0; i < 2; i++) begin m_tmr[i] = 0; m_tmo[i] = 0; end
        m_idx.delete(); m_addr.delete();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b0; sig_in = '0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input bit v, input logic [2:0] op,
                        input logic [31:0] ins, input logic [15:0] sin);
        logic [15:0] eff, val, e_addr;
        int a, b, fk;
        bit fire, sr, rr, nt [2];
        @(negedge clk);
        op_valid = v; op_code = op; instr = ins; pc = pcv; sig_in = sin;
        #1;
        eff = sin;
        if (m_tmo[0]) eff[14] = 1'b1;
        if (m_tmo[1]) eff[15] = 1'b1;
        val = ins[24:9]; a = int'(ins[8:5]); b = int'(ins[4:1]);
        fire = 0; fk = 0;
        for (int k = m_idx.size() - 1; k >= 0; k--)
            if (eff[m_idx[k]]) begin fire = 1; fk = k; end
        sr = 0; rr = 0;
        if (v) begin
            if (op == OP_WAIT)  sr = !eff[a];
            if (op == OP_DWAIT) begin sr = !eff[a] && !eff[b]; rr = !eff[a] && eff[b]; end
            if (op == OP_TEST)  rr = !eff[a];
            if (op == OP_DELAY) sr = m_busy ? (m_cnt != 0) : (val != 0);
        end
        e_addr = fire ? 16'(m_addr[fk]) : val;
        chk("R2 R3 sig_out", int'(sig_out), int'(m_pulse | m_held));
        chk("R4 R5 R7 R9 stall", int'(stall), int'(sr && !fire));
        chk("R5 R6 R9 R10 redirect", int'(redirect), int'(fire || rr));
        if (fire || rr) chk("R9 R10 redirect_addr", int'(redirect_addr), int'(e_addr));
        chk("R12 abort_ovf", int'(abort_ovf), int'(m_ovf));
        // advance the reference one clock
        for (int i = 0; i < 2; i++) begin
            nt[i] = (m_tmr[i] == 1);
            if (v && op == OP_TLOAD && int'(ins[0]) == i) m_tmr[i] = int'(val);
            else if (m_tmr[i] != 0) m_tmr[i]--;
            m_tmo[i] = nt[i];
        end
        m_pulse = (v && op == OP_PULSE) ? val : 16'h0;
        if (v && op == OP_LATCH) m_held = m_held | val;
        if (fire || !(v && op == OP_DELAY)) begin m_busy = 0; m_cnt = 0; end
        else if (!m_busy) begin if (val != 0) begin m_busy = 1; m_cnt = int'(val) - 1; end end
        else if (m_cnt == 0) m_busy = 0;
        else m_cnt--;
        if (fire) begin
            while (m_idx.size() > fk) begin void'(m_idx.pop_back()); void'(m_addr.pop_back()); end
        end else begin
            if (v && !sr)
                for (int k = m_idx.size() - 1; k >= 0; k--)
                    if (m_addr[k] == int'(pcv)) begin m_idx.delete(k); m_addr.delete(k); break; end
            if (v && op == OP_ABORT) begin
                if (m_idx.size() < 4) begin m_idx.push_back(a); m_addr.push_back(int'(val)); end
                else m_ovf = 1;
            end
        end
        pcv = pcv + 16'd1;
    endtask

    task automatic idle(input int n, input logic [15:0] sin);
        for (int i = 0; i < n; i++) step(0, OP_TLOAD, 32'h0, sin);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        pcv = 16'h0800;
        model_reset();
        do_reset();
        // R13 R1: idle after reset, invalid strobes do nothing
        idle(2, 16'h0);
        step(0, OP_PULSE, mk(16'hFFFF, 0, 0, 0), 16'h0);
        idle(1, 16'h0);
        // R2: multi-bit pulse, then gone
        step(1, OP_PULSE, mk(16'hA5A5, 0, 0, 0), 16'h0);
        idle(2, 16'h0);
        // R3: latched bits stay, pulse overlaps them
        step(1, OP_LATCH, mk(16'h0300, 0, 0, 0), 16'h0);
        step(1, OP_PULSE, mk(16'h0001, 0, 0, 0), 16'h0);
        idle(3, 16'h0);
        // R4: wait absent three cycles, then present
        for (int i = 0; i < 3; i++) step(1, OP_WAIT, mk(16'h0, 3, 0, 0), 16'h0);
        step(1, OP_WAIT, mk(16'h0, 3, 0, 0), 16'h0008);
        // R5: neither, second only, both, first only
        step(1, OP_DWAIT, mk(16'h1234, 2, 7, 0), 16'h0);
        step(1, OP_DWAIT, mk(16'h1234, 2, 7, 0), 16'h0080);
        step(1, OP_DWAIT, mk(16'h1234, 2, 7, 0), 16'h0084);
        step(1, OP_DWAIT, mk(16'h1234, 2, 7, 0), 16'h0004);
        // R6: present falls through, absent redirects
        step(1, OP_TEST, mk(16'h0ABC, 9, 0, 0), 16'h0200);
        step(1, OP_TEST, mk(16'h0ABC, 9, 0, 0), 16'h0);
        // R7: zero delay, then delay of three
        step(1, OP_DELAY, mk(16'd0, 0, 0, 0), 16'h0);
        for (int i = 0; i < 4; i++) step(1, OP_DELAY, mk(16'd3, 0, 0, 0), 16'h0);
        idle(1, 16'h0);
        // R8 R4: timer 0 timeout fed back on index 14
        step(1, OP_TLOAD, mk(16'd4, 0, 0, 0), 16'h0);
        for (int i = 0; i < 6; i++) step(1, OP_WAIT, mk(16'h0, 14, 0, 0), 16'h0);
        // R8: timer 1 on index 15, and a zero load stops a timer
        step(1, OP_TLOAD, mk(16'd2, 0, 0, 1), 16'h0);
        for (int i = 0; i < 4; i++) step(1, OP_TEST, mk(16'h0077, 15, 0, 0), 16'h0);
        step(1, OP_TLOAD, mk(16'd3, 0, 0, 1), 16'h0);
        step(1, OP_TLOAD, mk(16'd0, 0, 0, 1), 16'h0);
        for (int i = 0; i < 5; i++) step(1, OP_TEST, mk(16'h0077, 15, 0, 0), 16'h0);
        // R9: single level fires, pulse in the firing cycle still happens
        step(1, OP_ABORT, mk(16'h0040, 5, 0, 0), 16'h0);
        idle(2, 16'h0);
        step(1, OP_PULSE, mk(16'h0010, 0, 0, 0), 16'h0020);
        idle(2, 16'h0020);
        // R10: three nested, two fire together, outermost wins
        step(1, OP_ABORT, mk(16'h0100, 1, 0, 0), 16'h0);
        step(1, OP_ABORT, mk(16'h0200, 2, 0, 0), 16'h0);
        step(1, OP_ABORT, mk(16'h0300, 3, 0, 0), 16'h0);
        step(1, OP_PULSE, mk(16'h0000, 0, 0, 0), 16'h000C);
        idle(1, 16'h0008);
        idle(1, 16'h0002);
        idle(1, 16'h0);
        // R11: normal exit at inner continuation
        step(1, OP_ABORT, mk(16'h0050, 4, 0, 0), 16'h0);
        step(1, OP_ABORT, mk(16'h0060, 6, 0, 0), 16'h0);
        pcv = 16'h0060;
        step(1, OP_PULSE, mk(16'h0000, 0, 0, 0), 16'h0);
        pcv = 16'h0900;
        idle(1, 16'h0040);
        idle(1, 16'h0010);
        // R11: shared continuation removes only the innermost
        step(1, OP_ABORT, mk(16'h0070, 4, 0, 0), 16'h0);
        step(1, OP_ABORT, mk(16'h0070, 6, 0, 0), 16'h0);
        pcv = 16'h0070;
        step(1, OP_PULSE, mk(16'h0000, 0, 0, 0), 16'h0);
        pcv = 16'h0910;
        idle(1, 16'h0040);
        idle(1, 16'h0010);
        // R11: stalled operation at continuation does not pop
        step(1, OP_ABORT, mk(16'h0080, 4, 0, 0), 16'h0);
        pcv = 16'h0080;
        step(1, OP_WAIT, mk(16'h0, 3, 0, 0), 16'h0);
        pcv = 16'h0920;
        idle(1, 16'h0010);
        // R12: fifth level ignored, flag sticky
        for (int i = 0; i < 5; i++) step(1, OP_ABORT, mk(16'h0400 + 16'(i), 8 + i, 0, 0), 16'h0);
        idle(1, 16'h1000);
        idle(1, 16'h0800);
        idle(2, 16'h0);
        // R9 R7: abort cancels a running delay
        step(1, OP_ABORT, mk(16'h0500, 13, 0, 0), 16'h0);
        step(1, OP_DELAY, mk(16'd10, 0, 0, 0), 16'h0);
        step(1, OP_DELAY, mk(16'd10, 0, 0, 0), 16'h0);
        step(1, OP_DELAY, mk(16'd10, 0, 0, 0), 16'h2000);
        step(1, OP_DELAY, mk(16'd2, 0, 0, 0), 16'h0);
        step(1, OP_DELAY, mk(16'd2, 0, 0, 0), 16'h0);
        step(1, OP_DELAY, mk(16'd2, 0, 0, 0), 16'h0);
        // R9: abort arm in a firing cycle is dropped
        step(1, OP_ABORT, mk(16'h0600, 2, 0, 0), 16'h0);
        step(1, OP_ABORT, mk(16'h0700, 3, 0, 0), 16'h0004);
        idle(1, 16'h0008);
        // R13: reset with held outputs, armed level, running timer, overflow
        step(1, OP_ABORT, mk(16'h0650, 1, 0, 0), 16'h0);
        step(1, OP_TLOAD, mk(16'd3, 0, 0, 0), 16'h0);
        do_reset();
        for (int i = 0; i < 5; i++) step(1, OP_TEST, mk(16'h0033, 14, 0, 0), 16'h0002);
        idle(2, 16'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule